// File: doc/BRIEF.md
# Max-Min Fuzzy Rule Evaluator

This block runs one fuzzy inference pass over a programmable rule set. Each crisp input is a 6-bit index. It is turned into an 8-bit membership grade by looking it up in a writable membership table. The table is chosen per input and per fuzzy label. A rule's firing strength is the smallest of its antecedent grades. Every element of the rule's consequent set is limited to that strength, and the limited set is folded into an output set by taking the larger value at each element. Each output set has 64 elements.

The rule memory is read in one of two formats, chosen when an inference starts. The wide format holds four-antecedent, two-consequent rules, at most 51 of them, and produces two output sets. The narrow format packs two rules of two antecedents and one consequent into each word, at most 102 rules, and produces one output set. The rule, membership and consequent memories are loaded through one write port. After a start pulse, each rule occupies a fixed 64-cycle slot in a three-stage pipeline. The finished sets then stream out one element per cycle, and a done pulse marks the last element.

Top module: `fuzzy_maxmin_engine`

## Requirements
- R1: After synchronous reset, busy, out_valid and done are all low.
- R2: A write with wr_sel=1 stores wr_data[7:0] into the membership table at address {input[1:0], label[1:0], index[5:0]}. A write with wr_sel=2 stores it into the consequent table at address {label[2:0], element[5:0]}. A write with wr_sel=0 stores wr_data[13:0] into rule word wr_addr, for addresses 0 to 50. The grade for input i is the membership entry at {i, rule label for i, crisp_in[6i+5:6i]}.
- R3: A rule's firing strength is the minimum of its antecedent grades: four grades in the wide format, two in the narrow format.
- R4: Each rule contributes min(strength, consequent element) at every element. An output set element is the maximum of these contributions over all evaluated rules.
- R5: In the wide format, rule r is word r. Its antecedent labels for inputs 0 to 3 sit in bits [1:0], [3:2], [5:4] and [7:6]. The consequent label for set 0 is bits [10:8] and for set 1 is bits [13:11].
- R6: In the narrow format, rule r lies in word r/2: bits [6:0] when r is even, bits [13:7] when r is odd. Within that half, bits [1:0] label input 0, bits [3:2] label input 1, and bits [6:4] are the consequent label for set 0. out_set1 is zero for the whole stream.
- R7: The rule count is rule_cnt clamped to 51 in the wide format and to 102 in the narrow format. A count of zero yields all-zero output sets.
- R8: The first output element appears 64·N+2 cycles after the start edge, where N is the effective rule count. This holds whatever the firing strengths, including zero.
- R9: The output stream is 64 consecutive out_valid cycles with out_idx running 0 to 63. done is high only together with index 63, and busy is low in the cycle after it.
- R10: fmt_narrow, rule_cnt and crisp_in are sampled only on an accepted start. Changing them, or pulsing start, while busy has no effect on the running inference.
- R11: The output sets are cleared at every accepted start, so a result does not depend on earlier inferences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 2 | Target table: 0 rules, 1 membership, 2 consequent |
| wr_addr | input | 10 | Write address within the selected table |
| wr_data | input | 14 | Write data (grades use the low 8 bits) |
| fmt_narrow | input | 1 | 1 selects the two-input, one-output rule format |
| rule_cnt | input | 7 | Number of rules to evaluate |
| crisp_in | input | 24 | Four 6-bit crisp inputs, input i in bits [6i+5:6i] |
| start | input | 1 | Start an inference when idle |
| busy | output | 1 | Inference or output stream in progress |
| out_valid | output | 1 | An output element is presented |
| out_idx | output | 6 | Element index of the presented values |
| out_set0 | output | 8 | Output set 0 element |
| out_set1 | output | 8 | Output set 1 element |
| done | output | 1 | Last element of the stream |

## Verification
The bench keeps its own copy of every table. It computes the expected sets from that copy and compares the stream element by element. A design that read the wrong half of a narrow word, or swapped field positions, would put the wrong labels into the sets. A rule whose strength is forced to zero checks that its slot is not skipped; skipping it would shorten the start-to-first-element latency. Rule counts of zero and beyond the per-format limit check the clamp and the empty result. A change of format, count and crisp inputs, along with a second start, is applied partway through a run and must leave that run's result intact. A small inference run after a full 102-rule run catches accumulators that are not cleared, which would leave residue from the earlier pass.

// File: rtl/fz_pkg.sv
package fz_pkg;
    localparam int GRADE_W      = 8;
    localparam int IDX_W        = 6;
    localparam int SET_LEN      = 1 << IDX_W;
    localparam int N_IN         = 4;
    localparam int N_OUT        = 2;
    localparam int LBL_W        = 2;
    localparam int CLBL_W       = 3;
    localparam int WIDE_RULES   = 51;
    localparam int NARROW_RULES = 2 * WIDE_RULES;
    localparam int CNT_W        = $clog2(NARROW_RULES + 1);
    localparam int WORD_AW      = $clog2(WIDE_RULES);
    localparam int HALF_W       = 2 * LBL_W + CLBL_W;
    localparam int RULE_W       = N_IN * LBL_W + N_OUT * CLBL_W;
    localparam int MB_AW        = $clog2(N_IN) + LBL_W + IDX_W;
    localparam int CN_AW        = CLBL_W + IDX_W;
    localparam int WR_AW        = MB_AW;
    localparam int PIPE_DEPTH   = 3;
    localparam int DRAIN_CYC    = PIPE_DEPTH - 1;

    localparam logic [1:0] WS_RULE = 2'd0;
    localparam logic [1:0] WS_MEMB = 2'd1;
    localparam logic [1:0] WS_CONS = 2'd2;

    typedef logic [GRADE_W-1:0] grade_t;

    typedef struct packed {
        logic [CLBL_W-1:0] c1;
        logic [CLBL_W-1:0] c0;
        logic [LBL_W-1:0]  a3;
        logic [LBL_W-1:0]  a2;
        logic [LBL_W-1:0]  a1;
        logic [LBL_W-1:0]  a0;
    } wide_rule_t;

    typedef struct packed {
        logic [CLBL_W-1:0] c;
        logic [LBL_W-1:0]  a1;
        logic [LBL_W-1:0]  a0;
    } narrow_rule_t;

    typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_DRAIN, ST_EMIT} state_t;

    typedef struct packed {
        logic                    valid;
        logic                    narrow;
        logic [IDX_W-1:0]        elem;
        grade_t                  str;
        grade_t [N_OUT-1:0]      cons;
    } stage1_t;

    typedef struct packed {
        logic                    valid;
        logic [IDX_W-1:0]        elem;
        grade_t [N_OUT-1:0]      clip;
    } stage2_t;

    function automatic grade_t gmin(grade_t a, grade_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic grade_t gmax(grade_t a, grade_t b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/fz_mem.sv
module fz_mem
    import fz_pkg::*;
(
    input  logic                clk,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [WR_AW-1:0]    wr_addr,
    input  logic [RULE_W-1:0]   wr_data,
    input  logic [WORD_AW-1:0]  rd_word,
    output logic [RULE_W-1:0]   rule_word,
    input  logic [MB_AW-1:0]    mb_addr [N_IN],
    output grade_t              mb_grade [N_IN],
    input  logic [CN_AW-1:0]    cn_addr [N_OUT],
    output grade_t              cn_val [N_OUT]
);
    localparam int MB_DEPTH = 1 << MB_AW;
    localparam int CN_DEPTH = 1 << CN_AW;

    logic [RULE_W-1:0] rule_mem [WIDE_RULES];
    grade_t            memb_mem [MB_DEPTH];
    grade_t            cons_mem [CN_DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            case (wr_sel)
                WS_RULE: if (wr_addr < WR_AW'(WIDE_RULES))
                             rule_mem[wr_addr[WORD_AW-1:0]] <= wr_data;
                WS_MEMB: memb_mem[wr_addr] <= wr_data[GRADE_W-1:0];
                WS_CONS: cons_mem[wr_addr[CN_AW-1:0]] <= wr_data[GRADE_W-1:0];
                default: ;
            endcase
        end
    end

    assign rule_word = (rd_word < WORD_AW'(WIDE_RULES)) ? rule_mem[rd_word] : '0;

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_memb_rd
        assign mb_grade[gi] = memb_mem[mb_addr[gi]];
    end

    for (genvar go = 0; go < N_OUT; go++) begin : g_cons_rd
        assign cn_val[go] = cons_mem[cn_addr[go]];
    end
endmodule

// File: rtl/fz_ctrl.sv
module fz_ctrl
    import fz_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    fmt_narrow,
    input  logic [CNT_W-1:0]        rule_cnt,
    input  logic [N_IN*IDX_W-1:0]   crisp_in,
    output logic                    busy,
    output logic                    acc_clr,
    output logic                    iss_valid,
    output logic [CNT_W-1:0]        iss_rule,
    output logic [IDX_W-1:0]        iss_elem,
    output logic                    narrow_q,
    output logic [N_IN*IDX_W-1:0]   crisp_q,
    output logic                    emit_valid,
    output logic [IDX_W-1:0]        emit_idx,
    output logic                    done
);
    localparam logic [IDX_W-1:0] LAST_ELEM = IDX_W'(SET_LEN - 1);

    state_t             state_q;
    logic [CNT_W-1:0]   cnt_q, rule_q, limit, cnt_eff;
    logic [IDX_W-1:0]   elem_q, eidx_q;
    logic [1:0]         drain_q;

    always_comb begin
        limit   = fmt_narrow ? CNT_W'(NARROW_RULES) : CNT_W'(WIDE_RULES);
        cnt_eff = (rule_cnt > limit) ? limit : rule_cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            rule_q   <= '0;
            elem_q   <= '0;
            eidx_q   <= '0;
            drain_q  <= '0;
            narrow_q <= 1'b0;
            crisp_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    narrow_q <= fmt_narrow;
                    cnt_q    <= cnt_eff;
                    crisp_q  <= crisp_in;
                    rule_q   <= '0;
                    elem_q   <= '0;
                    drain_q  <= '0;
                    state_q  <= (cnt_eff == '0) ? ST_DRAIN : ST_EVAL;
                end
                ST_EVAL: begin
                    if (elem_q == LAST_ELEM) begin
                        elem_q <= '0;
                        if (rule_q == cnt_q - CNT_W'(1)) state_q <= ST_DRAIN;
                        else                             rule_q  <= rule_q + CNT_W'(1);
                    end else begin
                        elem_q <= elem_q + IDX_W'(1);
                    end
                end
                ST_DRAIN: begin
                    if (drain_q == 2'(DRAIN_CYC - 1)) begin
                        state_q <= ST_EMIT;
                        eidx_q  <= '0;
                    end else begin
                        drain_q <= drain_q + 2'd1;
                    end
                end
                default: begin
                    if (eidx_q == LAST_ELEM) state_q <= ST_IDLE;
                    else                     eidx_q  <= eidx_q + IDX_W'(1);
                end
            endcase
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign acc_clr    = (state_q == ST_IDLE) && start;
    assign iss_valid  = (state_q == ST_EVAL);
    assign iss_rule   = rule_q;
    assign iss_elem   = elem_q;
    assign emit_valid = (state_q == ST_EMIT);
    assign emit_idx   = eidx_q;
    assign done       = (state_q == ST_EMIT) && (eidx_q == LAST_ELEM);

    AST_RULE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EVAL) |-> (rule_q < cnt_q) && (cnt_q <= CNT_W'(NARROW_RULES))); // R7
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> $stable(narrow_q) && $stable(cnt_q) && $stable(crisp_q)); // R10
endmodule

// File: rtl/fz_pipe.sv
module fz_pipe
    import fz_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_clr,
    input  logic              iss_valid,
    input  logic              iss_narrow,
    input  logic [IDX_W-1:0]  iss_elem,
    input  grade_t            grade [N_IN],
    input  grade_t            cons [N_OUT],
    input  logic [IDX_W-1:0]  rd_idx,
    output grade_t            rd_val [N_OUT]
);
    stage1_t s1_q;
    stage2_t s2_q;
    grade_t  strength;

    always_comb begin
        if (iss_narrow) strength = gmin(grade[0], grade[1]);
        else            strength = gmin(gmin(grade[0], grade[1]), gmin(grade[2], grade[3]));
    end

    always_ff @(posedge clk) begin
        if (rst || acc_clr) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q.valid  <= iss_valid;
            s1_q.narrow <= iss_narrow;
            s1_q.elem   <= iss_elem;
            s1_q.str    <= strength;
            for (int k = 0; k < N_OUT; k++) s1_q.cons[k] <= cons[k];
            s2_q.valid  <= s1_q.valid;
            s2_q.elem   <= s1_q.elem;
            s2_q.clip[0] <= gmin(s1_q.str, s1_q.cons[0]);
            for (int k = 1; k < N_OUT; k++)
                s2_q.clip[k] <= s1_q.narrow ? '0 : gmin(s1_q.str, s1_q.cons[k]);
        end
    end

    for (genvar go = 0; go < N_OUT; go++) begin : g_acc
        grade_t bank [SET_LEN];

        always_ff @(posedge clk) begin
            if (rst || acc_clr) begin
                for (int e = 0; e < SET_LEN; e++) bank[e] <= '0;
            end else if (s2_q.valid) begin
                bank[s2_q.elem] <= gmax(bank[s2_q.elem], s2_q.clip[go]);
            end
        end

        assign rd_val[go] = bank[rd_idx];

        AST_AGG_COVERS_CLIP: assert property (@(posedge clk) disable iff (rst || acc_clr)
            s2_q.valid |=> bank[$past(s2_q.elem)] >= $past(s2_q.clip[go])); // R4
    end
endmodule

// File: rtl/fuzzy_maxmin_engine.sv
module fuzzy_maxmin_engine
    import fz_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [1:0]             wr_sel,
    input  logic [WR_AW-1:0]       wr_addr,
    input  logic [RULE_W-1:0]      wr_data,
    input  logic                   fmt_narrow,
    input  logic [CNT_W-1:0]       rule_cnt,
    input  logic [N_IN*IDX_W-1:0]  crisp_in,
    input  logic                   start,
    output logic                   busy,
    output logic                   out_valid,
    output logic [IDX_W-1:0]       out_idx,
    output logic [GRADE_W-1:0]     out_set0,
    output logic [GRADE_W-1:0]     out_set1,
    output logic                   done
);
    logic                   acc_clr, iss_valid, narrow_q, emit_valid;
    logic [CNT_W-1:0]       iss_rule;
    logic [IDX_W-1:0]       iss_elem, emit_idx;
    logic [N_IN*IDX_W-1:0]  crisp_q;
    logic [WORD_AW-1:0]     word_addr;
    logic [RULE_W-1:0]      rule_word;
    wide_rule_t             w_rule;
    narrow_rule_t           n_rule;
    logic [LBL_W-1:0]       lbl  [N_IN];
    logic [CLBL_W-1:0]      clbl [N_OUT];
    logic [MB_AW-1:0]       mb_addr [N_IN];
    logic [CN_AW-1:0]       cn_addr [N_OUT];
    grade_t                 mb_grade [N_IN];
    grade_t                 cn_val [N_OUT];
    grade_t                 rd_val [N_OUT];

    fz_ctrl u_ctrl (
        .clk, .rst, .start, .fmt_narrow, .rule_cnt, .crisp_in,
        .busy, .acc_clr, .iss_valid, .iss_rule, .iss_elem,
        .narrow_q, .crisp_q, .emit_valid, .emit_idx, .done
    );

    assign word_addr = narrow_q ? iss_rule[WORD_AW:1] : iss_rule[WORD_AW-1:0];

    fz_mem u_mem (
        .clk, .wr_en, .wr_sel, .wr_addr, .wr_data,
        .rd_word(word_addr), .rule_word,
        .mb_addr, .mb_grade, .cn_addr, .cn_val
    );

    always_comb begin
        w_rule = wide_rule_t'(rule_word);
        n_rule = iss_rule[0] ? narrow_rule_t'(rule_word[2*HALF_W-1:HALF_W])
                             : narrow_rule_t'(rule_word[HALF_W-1:0]);
        if (narrow_q) begin
            lbl[0]  = n_rule.a0;
            lbl[1]  = n_rule.a1;
            lbl[2]  = '0;
            lbl[3]  = '0;
            clbl[0] = n_rule.c;
            clbl[1] = '0;
        end else begin
            lbl[0]  = w_rule.a0;
            lbl[1]  = w_rule.a1;
            lbl[2]  = w_rule.a2;
            lbl[3]  = w_rule.a3;
            clbl[0] = w_rule.c0;
            clbl[1] = w_rule.c1;
        end
    end

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_fuzz_addr
        assign mb_addr[gi] = {2'(gi), lbl[gi], crisp_q[gi*IDX_W +: IDX_W]};
    end

    for (genvar go = 0; go < N_OUT; go++) begin : g_cons_addr
        assign cn_addr[go] = {clbl[go], iss_elem};
    end

    fz_pipe u_pipe (
        .clk, .rst, .acc_clr, .iss_valid, .iss_narrow(narrow_q), .iss_elem,
        .grade(mb_grade), .cons(cn_val), .rd_idx(emit_idx), .rd_val
    );

    assign out_valid = emit_valid;
    assign out_idx   = emit_idx;
    assign out_set0  = rd_val[0];
    assign out_set1  = rd_val[1];

    AST_START_TAKES: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy); // R10
    AST_IDX_ASCENDS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !done) |=> out_valid && (out_idx == $past(out_idx) + IDX_W'(1))); // R9
    AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (rst)
        done |-> out_valid && (out_idx == IDX_W'(SET_LEN - 1))); // R9
    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy && !done); // R9
    AST_NARROW_SET1_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && narrow_q) |-> (out_set1 == '0)); // R6
endmodule

// File: tb/fuzzy_maxmin_engine_tb.sv
module fuzzy_maxmin_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [9:0]  wr_addr = '0;
    logic [13:0] wr_data = '0;
    logic        fmt_narrow = 1'b0;
    logic [6:0]  rule_cnt = '0;
    logic [23:0] crisp_in = '0;
    logic        start = 1'b0;
    logic        busy, out_valid, done;
    logic [5:0]  out_idx;
    logic [7:0]  out_set0, out_set1;

    fuzzy_maxmin_engine u_dut (
        .clk, .rst, .wr_en, .wr_sel, .wr_addr, .wr_data, .fmt_narrow,
        .rule_cnt, .crisp_in, .start, .busy, .out_valid, .out_idx,
        .out_set0, .out_set1, .done
    );

    always #2 clk = ~clk;

    int bm [1024];
    int bc [512];
    int br [51];
    int q_idx[$], q_s0[$], q_s1[$];
    int n_chk = 0, n_fail = 0, cyc_total = 0;
    bit finished = 0;
    string cur_tag = "R1";
    int unsigned seed = 32'h1234_5678;

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed >> 16);
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc_total, 150000);
            finish_run();
        end
    end

    // monitor: pops expected elements as the stream appears
    always @(negedge clk) begin
        if (!rst && out_valid && !finished) begin
            if (q_idx.size() == 0) begin
                chk(0, "R9", "unexpected out_valid", 1, 0);
            end else begin
                int ei, e0, e1;
                ei = q_idx.pop_front();
                e0 = q_s0.pop_front();
                e1 = q_s1.pop_front();
                chk(int'(out_idx) == ei, "R9", "out_idx", int'(out_idx), ei);
                chk(int'(out_set0) == e0, cur_tag, $sformatf("set0[%0d]", ei), int'(out_set0), e0);
                chk(int'(out_set1) == e1, cur_tag, $sformatf("set1[%0d]", ei), int'(out_set1), e1);
                chk(done == (ei == 63), "R9", "done", int'(done), int'(ei == 63));
            end
        end
    end

    task automatic wr(int sel, int addr, int data);
        wr_en   = 1'b1;
        wr_sel  = 2'(sel);
        wr_addr = 10'(addr);
        wr_data = 14'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic int imin(int a, int b);
        return (a < b) ? a : b;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // driver: builds expected sets from the bench tables and starts a run
    task automatic run(bit nar, int cnt, int x0, int x1, int x2, int x3, string tag, bit perturb);
        int eff, lim, cyc, e0[64], e1[64], xs[4];
        xs[0] = x0; xs[1] = x1; xs[2] = x2; xs[3] = x3;
        lim = nar ? 102 : 51;
        eff = (cnt > lim) ? lim : cnt;
        for (int e = 0; e < 64; e++) begin e0[e] = 0; e1[e] = 0; end
        for (int r = 0; r < eff; r++) begin
            if (nar) begin
                int h, s, c;
                h = (r % 2 == 1) ? (br[r/2] >> 7) & 127 : br[r/2] & 127;
                s = imin(bm[0*256 + (h & 3)*64 + xs[0]], bm[1*256 + ((h >> 2) & 3)*64 + xs[1]]);
                c = (h >> 4) & 7;
                for (int e = 0; e < 64; e++) e0[e] = imax(e0[e], imin(s, bc[c*64 + e]));
            end else begin
                int w, s, c0, c1;
                w = br[r];
                s = 255;
                for (int i = 0; i < 4; i++) s = imin(s, bm[i*256 + ((w >> (2*i)) & 3)*64 + xs[i]]);
                c0 = (w >> 8) & 7;
                c1 = (w >> 11) & 7;
                for (int e = 0; e < 64; e++) begin
                    e0[e] = imax(e0[e], imin(s, bc[c0*64 + e]));
                    e1[e] = imax(e1[e], imin(s, bc[c1*64 + e]));
                end
            end
        end
        for (int e = 0; e < 64; e++) begin
            q_idx.push_back(e);
            q_s0.push_back(e0[e]);
            q_s1.push_back(e1[e]);
        end
        cur_tag    = tag;
        fmt_narrow = nar;
        rule_cnt   = 7'(cnt);
        crisp_in   = {6'(x3), 6'(x2), 6'(x1), 6'(x0)};
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!out_valid) begin
            @(negedge clk);
            cyc++;
            if (perturb && cyc == 3) begin
                fmt_narrow = ~nar;
                rule_cnt   = 7'd1;
                crisp_in   = ~crisp_in;
                start      = 1'b1;
            end else if (perturb && cyc == 4) begin
                start = 1'b0;
            end
        end
        chk(cyc == 64*eff + 3, "R8", "start-to-first-element cycles", cyc, 64*eff + 3);
        while (q_idx.size() > 0) @(negedge clk);
        chk(busy == 1'b0, "R9", "busy after done", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(done == 1'b0, "R1", "done after reset", int'(done), 0);

        // load tables through the write port (R2)
        for (int a = 0; a < 1024; a++) begin
            int v;
            v = rnd() & 255;
            if (v < 40) v = 0;
            bm[a] = v;
            wr(1, a, v);
        end
        for (int a = 0; a < 512; a++) begin
            bc[a] = rnd() & 255;
            wr(2, a, bc[a]);
        end
        for (int a = 0; a < 51; a++) begin
            br[a] = rnd() & 16383;
            wr(0, a, br[a]);
        end

        run(0, 3, 5, 17, 40, 63, "R2 R3 R4 R5", 0);
        run(0, 7, 0, 63, 31, 9, "R3 R4 R5", 0);
        run(1, 5, 12, 50, 0, 0, "R6 R3 R4", 0);
        run(1, 2, 33, 7, 0, 0, "R6", 0);

        // force rule 0 to zero strength: its slot must still be spent
        bm[0*256 + (br[0] & 3)*64 + 20] = 0;
        wr(0 + 1, 0*256 + (br[0] & 3)*64 + 20, 0);
        run(0, 1, 20, 3, 4, 5, "R8 R3", 0);
        run(0, 2, 20, 3, 4, 5, "R8 R4", 0);

        run(0, 0, 1, 2, 3, 4, "R7", 0);
        run(0, 127, 11, 22, 33, 44, "R7 R5", 0);
        run(1, 127, 45, 19, 0, 0, "R7 R6", 0);
        run(1, 1, 45, 19, 0, 0, "R11", 0);
        run(0, 4, 8, 16, 24, 32, "R10", 1);
        run(1, 3, 2, 61, 0, 0, "R10 R6", 1);

        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R10", "no stray stream after runs", int'(out_valid), 0);
        finish_run();
    end
endmodule